// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

A bank of identical GPIO pin cells, each with a tiny register set reached through a single-cycle synchronous read/write port. Every cell resynchronizes its pad input and watches it for a configured event: a level (high or low), a rising edge, a falling edge, or any edge. A qualifying event latches a sticky status bit. The status bit stays set until software clears it.

The status bit becomes an interrupt request only while the pin's enable bit is set and its routing field selects the application processor. Each cell also holds an output data bit and an output-enable bit that drive the pad. The bank exposes registered per-pin requests and one registered summary request for the application processor.

Software masks a pin by clearing its enable bit, which leaves the rest of its configuration unchanged. To unmask a pin, software clears the status bit first and then sets enable.

Top module: `gpio_irq_bank`

## Requirements
- R1: After a synchronous reset every configuration field, every status bit, the output data and output-enable bits, `rd_data`, `irq_pin` and `irq_app` are 0.
- R2: The register address is {pin index, select}, with a 2-bit select in the low bits. Select 0 is the I/O register: bit 0 returns the synchronized pad level (read-only), bit 1 is output data and drives `pad_out`, and bit 2 is output enable and drives `pad_oe`. Select 3 reads as 0.
- R3: Select 1 is the configuration register, which reads back exactly what was written. Its fields are: bit 0 enable, bit 1 polarity, bits 3:2 detection mode, bit 4 raw-status enable, and bits 7:5 target.
- R4: Detection mode 0 is level-sensitive. The pin's event is active while the synchronized level equals the polarity bit (1 = high, 0 = low).
- R5: Mode 1 detects rising edges, mode 2 detects falling edges and mode 3 detects both. An edge is a difference between the current and the previous synchronized sample.
- R6: Select 2 is the status register, with the status in bit 0, and the status bit is sticky. Writing bit 0 as 0 clears it. Writing bit 0 as 1 has no effect.
- R7: When an event and a status clear occur in the same cycle, the event wins and the status stays 1.
- R8: Status is latched on an event whether or not the enable bit is set, provided raw-status enable is 1. With raw-status enable at 0 no status is latched. Enable only gates the request.
- R9: A pin raises its request only when status, enable and target == 4 all hold. `irq_app` is the OR of all pin requests.
- R10: Latency: a pad change made before clock edge 1 shows on `irq_pin`/`irq_app` after edge 4. Read data appears after the clock edge that samples `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | {pin index, register select} |
| wdata | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| pad_in | input | NUM_PINS | Asynchronous pad levels |
| pad_out | output | NUM_PINS | Output data per pad |
| pad_oe | output | NUM_PINS | Output enable per pad |
| irq_pin | output | NUM_PINS | Registered per-pin interrupt requests |
| irq_app | output | 1 | Registered summary request to the application processor |

## Verification
A pad change driven just after an edge passes two synchronizer flops, the status flop and the request flop. It therefore shows on the request outputs after the fourth rising edge. The bench checks for a low request after three edges and a high request after four. Every other event check waits at least five cycles before it samples.

Register writes take effect at the single edge inside the write task. Read data is sampled on the falling edge that follows the edge which captured `rd_en`. All sampling happens on falling edges, away from the edge that updates state.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int SEL_W = 2;

  typedef enum logic [1:0] {
    DET_LEVEL = 2'd0,
    DET_RISE  = 2'd1,
    DET_FALL  = 2'd2,
    DET_BOTH  = 2'd3
  } det_mode_e;

  // bit 0 enable, bit 1 polarity, bits 3:2 mode, bit 4 raw-status enable, bits 7:5 target
  typedef struct packed {
    logic [2:0] target;
    logic       raw_en;
    det_mode_e  mode;
    logic       pol;
    logic       en;
  } cfg_t;

  localparam int REG_W = $bits(cfg_t);

  localparam logic [2:0]       TGT_APP  = 3'd4;
  localparam logic [SEL_W-1:0] SEL_IO   = 2'd0;
  localparam logic [SEL_W-1:0] SEL_CFG  = 2'd1;
  localparam logic [SEL_W-1:0] SEL_STAT = 2'd2;
endpackage

// File: rtl/gpio_pad_sync.sv
module gpio_pad_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pad_i,
  output logic sync_o,
  output logic prev_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], pad_i};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign sync_o = chain_q[STAGES-1];
  assign prev_o = prev_q;
endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect
  import gpio_irq_pkg::*;
(
  input  logic      sync_i,
  input  logic      prev_i,
  input  det_mode_e mode_i,
  input  logic      pol_i,
  output logic      evt_o
);
  logic rise, fall;

  assign rise = sync_i & ~prev_i;
  assign fall = ~sync_i & prev_i;

  always_comb begin
    unique case (mode_i)
      DET_LEVEL: evt_o = (sync_i == pol_i);
      DET_RISE:  evt_o = rise;
      DET_FALL:  evt_o = fall;
      DET_BOTH:  evt_o = rise | fall;
      default:   evt_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
  import gpio_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             pad_i,
  output logic [REG_W-1:0] rdata_o,
  output logic             pad_out_o,
  output logic             pad_oe_o,
  output logic             req_o
);
  cfg_t cfg_q;
  logic status_q, out_q, oe_q;
  logic sync, prev, evt, clr;

  gpio_pad_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pad_i(pad_i), .sync_o(sync), .prev_o(prev)
  );

  gpio_evt_detect u_det (
    .sync_i(sync), .prev_i(prev), .mode_i(cfg_q.mode), .pol_i(cfg_q.pol), .evt_o(evt)
  );

  assign clr = wr_i && (sel_i == SEL_STAT) && !wdata_i[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q    <= '0;
      status_q <= 1'b0;
      out_q    <= 1'b0;
      oe_q     <= 1'b0;
    end else begin
      if (wr_i && sel_i == SEL_CFG) cfg_q <= cfg_t'(wdata_i);
      if (wr_i && sel_i == SEL_IO) begin
        out_q <= wdata_i[1];
        oe_q  <= wdata_i[2];
      end
      if (evt && cfg_q.raw_en) status_q <= 1'b1;
      else if (clr)            status_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (sel_i)
      SEL_IO:   rdata_o = REG_W'({oe_q, out_q, sync});
      SEL_CFG:  rdata_o = cfg_q;
      SEL_STAT: rdata_o = REG_W'(status_q);
      default:  rdata_o = '0;
    endcase
  end

  assign pad_out_o = out_q;
  assign pad_oe_o  = oe_q;
  assign req_o     = status_q && cfg_q.en && (cfg_q.target == TGT_APP);

  // R6: status stays set unless a clear write arrives
  a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
    (status_q && !clr) |=> status_q);
  // R7: a qualifying event always leaves status set, even against a clear
  a_r7_event_wins: assert property (@(posedge clk) disable iff (rst)
    (evt && cfg_q.raw_en) |=> status_q);
  // R8: with raw-status enable off, a clear status remains clear
  a_r8_raw_block: assert property (@(posedge clk) disable iff (rst)
    (!cfg_q.raw_en && !status_q) |=> !status_q);
  // R5: a rising-mode event only follows a rise of the synchronized level
  a_r5_rise_only: assert property (@(posedge clk) disable iff (rst)
    (cfg_q.mode == DET_RISE && evt) |-> $rose(sync));
  // R5: a falling-mode event only follows a fall of the synchronized level
  a_r5_fall_only: assert property (@(posedge clk) disable iff (rst)
    (cfg_q.mode == DET_FALL && evt) |-> $fell(sync));
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter  int NUM_PINS    = 4,
  parameter  int SYNC_STAGES = 2,
  localparam int PIN_W       = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1,
  localparam int ADDR_W      = PIN_W + SEL_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [REG_W-1:0]    wdata,
  output logic [REG_W-1:0]    rd_data,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic [NUM_PINS-1:0] irq_pin,
  output logic                irq_app
);
  logic [PIN_W-1:0]    pin_idx;
  logic [SEL_W-1:0]    sel;
  logic [NUM_PINS-1:0] cell_wr, cell_req;
  logic [REG_W-1:0]    cell_rdata [NUM_PINS];
  logic [REG_W-1:0]    rd_mux, rd_q;
  logic [NUM_PINS-1:0] irq_q;
  logic                app_q;

  assign pin_idx = addr[ADDR_W-1:SEL_W];
  assign sel     = addr[SEL_W-1:0];

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    assign cell_wr[i] = wr_en && (pin_idx == PIN_W'(i));

    gpio_pin_cell #(.SYNC_STAGES(SYNC_STAGES)) u_cell (
      .clk(clk), .rst(rst), .wr_i(cell_wr[i]), .sel_i(sel), .wdata_i(wdata),
      .pad_i(pad_in[i]), .rdata_o(cell_rdata[i]), .pad_out_o(pad_out[i]),
      .pad_oe_o(pad_oe[i]), .req_o(cell_req[i])
    );

    // R9: a registered pin request traces back to that pin's request
    a_r9_pin_route: assert property (@(posedge clk) disable iff (rst)
      irq_q[i] |-> $past(cell_req[i]));
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_PINS; i++)
      if (pin_idx == PIN_W'(i)) rd_mux = cell_rdata[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q  <= '0;
      irq_q <= '0;
      app_q <= 1'b0;
    end else begin
      rd_q  <= rd_en ? rd_mux : '0;
      irq_q <= cell_req;
      app_q <= |cell_req;
    end
  end

  assign rd_data = rd_q;
  assign irq_pin = irq_q;
  assign irq_app = app_q;

  // R1: outputs are quiet in the first cycle after reset releases
  a_r1_post_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!irq_app && irq_pin == '0 && rd_data == '0));
  // R9: the summary request agrees with the per-pin requests
  a_r9_summary: assert property (@(posedge clk) disable iff (rst)
    irq_app == (irq_pin != '0));
endmodule

// File: tb/gpio_irq_bank_tb.sv
`timescale 1ns/1ps
module gpio_irq_bank_tb;
  localparam int NP = 4;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    wdata = '0;
  logic [7:0]    rd_data;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_out, pad_oe, irq_pin;
  logic          irq_app;

  int n_chk = 0, n_err = 0, cycles = 0;

  always #2.5 clk = ~clk;

  gpio_irq_bank #(.NUM_PINS(NP)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rd_data(rd_data), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .irq_pin(irq_pin), .irq_app(irq_app)
  );

  // vector fields: {mode[1:0], polarity, pad before, pad after, expected status}
  localparam logic [5:0] VECS [12] = '{
    6'b01_1_0_1_1, 6'b01_1_1_0_0, 6'b10_1_1_0_1, 6'b10_1_0_1_0,
    6'b11_1_0_1_1, 6'b11_1_1_0_1, 6'b00_1_0_1_1, 6'b00_1_0_0_0,
    6'b00_0_1_0_1, 6'b00_0_1_1_0, 6'b01_1_0_0_0, 6'b11_1_1_1_0
  };

  function automatic logic [AW-1:0] ra(int pin, int sel);
    return {2'(pin), 2'(sel)};
  endfunction

  function automatic logic [7:0] cf(logic [2:0] tgt, logic raw, logic [1:0] mode,
                                    logic pol, logic en);
    return {tgt, raw, mode, pol, en};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      finish_run();
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq_app", irq_app, 0);
    chk("R1 irq_pin", irq_pin, 0);
    chk("R1 pad_oe", pad_oe, 0);
    chk("R1 pad_out", pad_out, 0);
    rd(ra(0, 1), d); chk("R1 cfg", d, 0);
    rd(ra(0, 2), d); chk("R1 status", d, 0);
    rd(ra(0, 0), d); chk("R1 io", d, 0);

    // R4 R5 vector walk
    for (int i = 0; i < 12; i++) begin
      int p;
      logic [5:0] v;
      p = i % NP;
      v = VECS[i];
      wr(ra(p, 1), 8'h00); wr(ra(p, 2), 8'h00);
      pad_in[p] = v[2];
      repeat (4) @(negedge clk);
      wr(ra(p, 1), cf(3'd4, 1'b1, v[5:4], v[3], 1'b1));
      wr(ra(p, 2), 8'h00);
      pad_in[p] = v[1];
      repeat (5) @(negedge clk);
      rd(ra(p, 2), d);
      chk((v[5:4] == 2'd0) ? "R4 status" : "R5 status", d, 32'(v[0]));
      chk("R9 irq_app", irq_app, 32'(v[0]));
      chk("R9 irq_pin", irq_pin[p], 32'(v[0]));
      wr(ra(p, 1), 8'h00); wr(ra(p, 2), 8'h00);
    end

    // R10 latency from pad change to request
    pad_in = '0;
    repeat (4) @(negedge clk);
    wr(ra(1, 1), cf(3'd4, 1'b1, 2'd1, 1'b1, 1'b1));
    @(negedge clk);
    pad_in[1] = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 not yet", irq_app, 0);
    @(negedge clk);
    chk("R10 due", irq_app, 1);
    pad_in[1] = 1'b0;
    repeat (4) @(negedge clk);
    rd(ra(1, 2), d); chk("R6 sticky after pad fall", d, 1);
    wr(ra(1, 1), 8'h00); wr(ra(1, 2), 8'h00);

    // R8 status latched while masked, enable gates request
    pad_in[2] = 1'b1;
    wr(ra(2, 1), cf(3'd4, 1'b1, 2'd0, 1'b1, 1'b0));
    repeat (5) @(negedge clk);
    rd(ra(2, 2), d); chk("R8 status masked", d, 1);
    chk("R8 no req masked", irq_app, 0);
    wr(ra(2, 1), cf(3'd4, 1'b1, 2'd0, 1'b1, 1'b1));
    @(negedge clk);
    chk("R8 req after enable", irq_pin, 4'b0100);
    rd(ra(2, 1), d); chk("R3 cfg readback", d, cf(3'd4, 1'b1, 2'd0, 1'b1, 1'b1));
    // R9 other target
    wr(ra(2, 1), cf(3'd3, 1'b1, 2'd0, 1'b1, 1'b1));
    @(negedge clk);
    chk("R9 wrong target", irq_app, 0);
    // R7 event wins over clear
    wr(ra(2, 2), 8'h00);
    rd(ra(2, 2), d); chk("R7 event wins", d, 1);
    // R6 clear and write-one
    pad_in[2] = 1'b0;
    repeat (4) @(negedge clk);
    wr(ra(2, 2), 8'h00);
    rd(ra(2, 2), d); chk("R6 cleared", d, 0);
    wr(ra(2, 2), 8'h01);
    rd(ra(2, 2), d); chk("R6 write one ignored", d, 0);
    // R8 raw-status enable off
    wr(ra(2, 1), cf(3'd4, 1'b0, 2'd0, 1'b1, 1'b1));
    pad_in[2] = 1'b1;
    repeat (5) @(negedge clk);
    rd(ra(2, 2), d); chk("R8 raw off status", d, 0);
    chk("R8 raw off irq", irq_app, 0);

    // R2 I/O register
    wr(ra(3, 0), 8'h06);
    chk("R2 pad_out", pad_out[3], 1);
    chk("R2 pad_oe", pad_oe[3], 1);
    pad_in[3] = 1'b1;
    repeat (3) @(negedge clk);
    rd(ra(3, 0), d); chk("R2 io read", d, 8'h07);
    rd(ra(3, 3), d); chk("R2 unused select", d, 0);

    finish_run();
  end
endmodule